// File: doc/BRIEF.md
# Dual-Link Receiver Output Controller

This block sits beside the pixel output stage of a video link receiver that may be paired with a second, identical receiver to split one panel's pixel stream across two links. It decides which pixel layout the local receiver uses and which of its output groups are enabled. The groups are the first-pixel bus, the second-pixel bus, the timing group (clock, data enable, syncs) and the general control line 1. From the same inputs it also produces a configuration error flag and the data-enable reference that paces the local pixel bus.

The block takes three configuration inputs. The pairing input is high for a two-link arrangement; on the primary receiver it is fed from the partner's link-detect flag. The role input selects primary or partner when pairing is high, and selects one or two pixels per clock when pairing is low. Together with the local link-detect flag, a chip enable and an output-driver enable, these inputs give the layout and the enables. A layout change waits until the local data enable is low, so no line is split between layouts. Every output comes from a flop, so all groups switch on the same clock edge.

Top module: `dlink_out_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, all four enables, `two_pix`, `line_de` and `cfg_err` are low, and the committed layout is one pixel per clock on a single link.
- R2: When `chip_en` is low at a clock edge, `even_en`, `odd_en`, `tim_en` and `ctl1_en` are all low after that edge.
- R3: When `drv_en` is low (with `chip_en` and `link_up` high), `even_en`, `odd_en` and `tim_en` are low after the edge, and `ctl1_en` stays high.
- R4: When `link_up` is low, all four enables are low after the edge. This holds for the primary and the partner role alike.
- R5: With `pair_mode` low, `role_sel` high commits two pixels per clock (`two_pix`=1) and `role_sel` low commits one pixel per clock (`two_pix`=0). In both cases `odd_en` follows `even_en`.
- R6: With `pair_mode` high and `role_sel` high (primary), the block commits one pixel per clock (`two_pix`=0) with `odd_en` low while `even_en` is high.
- R7: With `pair_mode` high and `role_sel` low (partner), the block commits one pixel per clock with `odd_en` high, and `line_de` follows `sync_de` one edge later. In every other layout, `line_de` follows `de` one edge later.
- R8: A new layout is committed only at an edge where `de` is low. While `de` is high, `two_pix`, `odd_en` and the `line_de` source keep their previous layout.
- R9: `cfg_err` is high after an edge where `clk_inv_req` and `pair_mode` are both high, and low after any other edge.
- R10: Every output reflects the inputs sampled at the preceding rising edge, so all groups change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Low disables every output group |
| drv_en | input | 1 | Low disables all groups except control line 1 |
| pair_mode | input | 1 | High: two-link arrangement |
| role_sel | input | 1 | Pairing high: 1 primary, 0 partner. Pairing low: 1 two pixels, 0 one pixel |
| link_up | input | 1 | Local link-detect flag |
| de | input | 1 | Local data enable |
| sync_de | input | 1 | Primary's data enable as seen by the partner |
| clk_inv_req | input | 1 | Request for an inverted output clock |
| two_pix | output | 1 | Committed layout is two pixels per clock |
| even_en | output | 1 | First-pixel bus enable |
| odd_en | output | 1 | Second-pixel bus enable |
| tim_en | output | 1 | Clock, data-enable and sync group enable |
| ctl1_en | output | 1 | Control line 1 enable |
| line_de | output | 1 | Data-enable reference pacing the local bus |
| cfg_err | output | 1 | Clock inversion requested in a two-link arrangement |

## Verification
A layout request can arrive in the same cycle as a high data enable. The block must then defer the new layout and keep the old one. The bench provokes this by changing `pair_mode` and `role_sel` while `de` is high. It judges the cycle by whether `two_pix`, `odd_en` and the `line_de` source still match the old layout, and then by whether they switch at the first edge with `de` low. A power gate can also coincide with a layout commit. The bench drops `drv_en` or `link_up` in the cycle of a commit and checks that the enables follow the gate while `two_pix` follows the new layout.

// File: rtl/dlink_pkg.sv
package dlink_pkg;

   typedef enum logic [1:0] {
      MODE_S1P  = 2'd0,
      MODE_S2P  = 2'd1,
      MODE_DMST = 2'd2,
      MODE_DSLV = 2'd3
   } link_mode_e;

   function automatic link_mode_e pick_mode(input logic pair, input logic role);
      link_mode_e m;
      if (pair) m = role ? MODE_DMST : MODE_DSLV;
      else      m = role ? MODE_S2P  : MODE_S1P;
      return m;
   endfunction

endpackage

// File: rtl/dlink_mode_sel.sv
module dlink_mode_sel
   import dlink_pkg::*;
#(
   parameter link_mode_e RST_MODE = MODE_S1P
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pair_mode,
   input  logic       role_sel,
   input  logic       de,
   output link_mode_e mode_next,
   output link_mode_e mode_q
);

   link_mode_e want;

   always_comb begin
      want      = pick_mode(pair_mode, role_sel);
      mode_next = de ? mode_q : want;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= RST_MODE;
      else        mode_q <= mode_next;
   end

   // R8: the committed layout holds across an edge with de high
   a_r8_hold_in_line: assert property (@(posedge clk) disable iff (!rst_n)
      de |=> $stable(mode_q));

endmodule

// File: rtl/dlink_enable_gen.sv
module dlink_enable_gen
   import dlink_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       chip_en,
   input  logic       drv_en,
   input  logic       link_up,
   input  link_mode_e mode_next,
   output logic       two_pix,
   output logic       even_en,
   output logic       odd_en,
   output logic       tim_en,
   output logic       ctl1_en
);

   logic live, gated;

   always_comb begin
      live  = chip_en & link_up;
      gated = live & drv_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         two_pix <= 1'b0;
         even_en <= 1'b0;
         odd_en  <= 1'b0;
         tim_en  <= 1'b0;
         ctl1_en <= 1'b0;
      end else begin
         two_pix <= (mode_next == MODE_S2P);
         even_en <= gated;
         odd_en  <= gated & (mode_next != MODE_DMST);
         tim_en  <= gated;
         ctl1_en <= live;
      end
   end

   a_r2_chip_off: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> !even_en && !odd_en && !tim_en && !ctl1_en);

   a_r3_drv_off: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_en |=> !even_en && !odd_en && !tim_en);

   a_r4_link_down: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |=> !even_en && !ctl1_en);

   a_r6_two_pix_alone: assert property (@(posedge clk) disable iff (!rst_n)
      two_pix |-> !(even_en && !odd_en));

endmodule

// File: rtl/dlink_aux.sv
module dlink_aux
   import dlink_pkg::*;
#(
   parameter bit ERR_STICKY = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  link_mode_e mode_next,
   input  logic       de,
   input  logic       sync_de,
   input  logic       pair_mode,
   input  logic       clk_inv_req,
   output logic       line_de,
   output logic       cfg_err
);

   logic bad_now;
   assign bad_now = clk_inv_req & pair_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_de <= 1'b0;
      else        line_de <= (mode_next == MODE_DSLV) ? sync_de : de;
   end

   generate
      if (ERR_STICKY) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cfg_err <= 1'b0;
            else if (!clk_inv_req) cfg_err <= 1'b0;
            else if (bad_now)      cfg_err <= 1'b1;
         end
      end else begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cfg_err <= 1'b0;
            else        cfg_err <= bad_now;
         end
         // R9: a raised error always traces back to an inversion request
         a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cfg_err) |-> $past(clk_inv_req) && $past(pair_mode));
      end
   endgenerate

endmodule

// File: rtl/dlink_out_ctrl.sv
module dlink_out_ctrl
   import dlink_pkg::*;
#(
   parameter link_mode_e RST_MODE   = MODE_S1P,
   parameter bit         ERR_STICKY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_en,
   input  logic drv_en,
   input  logic pair_mode,
   input  logic role_sel,
   input  logic link_up,
   input  logic de,
   input  logic sync_de,
   input  logic clk_inv_req,
   output logic two_pix,
   output logic even_en,
   output logic odd_en,
   output logic tim_en,
   output logic ctl1_en,
   output logic line_de,
   output logic cfg_err
);

   link_mode_e mode_next, mode_q;

   initial begin
      a_rst_mode_legal: assert (RST_MODE == MODE_S1P || RST_MODE == MODE_S2P)
         else $display("dlink_out_ctrl: reset layout must be a single-link layout");
   end

   dlink_mode_sel #(.RST_MODE(RST_MODE)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .pair_mode (pair_mode),
      .role_sel  (role_sel),
      .de        (de),
      .mode_next (mode_next),
      .mode_q    (mode_q)
   );

   dlink_enable_gen u_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .chip_en   (chip_en),
      .drv_en    (drv_en),
      .link_up   (link_up),
      .mode_next (mode_next),
      .two_pix   (two_pix),
      .even_en   (even_en),
      .odd_en    (odd_en),
      .tim_en    (tim_en),
      .ctl1_en   (ctl1_en)
   );

   dlink_aux #(.ERR_STICKY(ERR_STICKY)) u_aux (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_next   (mode_next),
      .de          (de),
      .sync_de     (sync_de),
      .pair_mode   (pair_mode),
      .clk_inv_req (clk_inv_req),
      .line_de     (line_de),
      .cfg_err     (cfg_err)
   );

   // R6: the primary of a pair never drives its second-pixel bus
   a_r6_primary_odd_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_DMST) |-> !odd_en);

   // R5: two pixels per clock only in the single-link two-pixel layout
   a_r5_two_pix_layout: assert property (@(posedge clk) disable iff (!rst_n)
      two_pix |-> (mode_q == MODE_S2P));

endmodule

// File: tb/dlink_out_ctrl_tb.sv
module dlink_out_ctrl_tb;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chip_en = 0, drv_en = 0, pair_mode = 0, role_sel = 0, link_up = 0;
   logic de = 0, sync_de = 0, clk_inv_req = 0;
   logic two_pix, even_en, odd_en, tim_en, ctl1_en, line_de, cfg_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   dlink_out_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .drv_en(drv_en),
      .pair_mode(pair_mode), .role_sel(role_sel), .link_up(link_up),
      .de(de), .sync_de(sync_de), .clk_inv_req(clk_inv_req),
      .two_pix(two_pix), .even_en(even_en), .odd_en(odd_en), .tim_en(tim_en),
      .ctl1_en(ctl1_en), .line_de(line_de), .cfg_err(cfg_err)
   );

   typedef struct {
      logic [6:0] val;   // {two, even, odd, tim, ctl1, lde, err}
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   logic done = 0;

   // bench model of the committed layout: 0 s1p, 1 s2p, 2 primary, 3 partner
   int m_mode = 0;

   function automatic logic [6:0] cur_obs();
      return {two_pix, even_en, odd_en, tim_en, ctl1_en, line_de, cfg_err};
   endfunction

   task automatic compare(input logic [6:0] act, input logic [6:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got two/even/odd/tim/ctl1/lde/err=%b expected %b", tag, act, exp);
      end
   endtask

   task automatic step(input logic c, input logic dv, input logic lk, input logic pr,
                       input logic rl, input logic d, input logic sd, input logic inv,
                       input string tag);
      exp_t e;
      logic live, gated, t2, od, lde;
      @(negedge clk);
      chip_en = c; drv_en = dv; link_up = lk; pair_mode = pr; role_sel = rl;
      de = d; sync_de = sd; clk_inv_req = inv;
      if (!d) m_mode = pr ? (rl ? 2 : 3) : (rl ? 1 : 0);
      live  = c & lk;
      gated = live & dv;
      t2    = (m_mode == 1);
      od    = gated & (m_mode != 2);
      lde   = (m_mode == 3) ? sd : d;
      e.val = {t2, gated, od, gated, live, lde, inv & pr};
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: after each rising edge, compare the oldest pending expectation
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            compare(cur_obs(), e.val, e.tag);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] lfsr;
      repeat (3) @(negedge clk);
      compare(cur_obs(), 7'b0, "R1 reset state");
      @(negedge clk);
      rst_n = 1'b1;
      // R1: first edge after reset with de high keeps the reset layout (one pixel)
      step(1,1,1,0,1,1,0,0, "R1 reset layout held");
      // R5 single link layouts
      step(1,1,1,0,1,0,0,0, "R5 single two-pixel");
      step(1,1,1,0,0,0,0,0, "R5 single one-pixel");
      step(1,1,1,0,1,0,0,0, "R5 back to two-pixel");
      // R8 request to primary while de high: keep two-pixel layout
      step(1,1,1,1,1,1,0,0, "R8 deferred during line");
      step(1,1,1,1,1,1,1,0, "R8 still deferred");
      // R6 commit primary when de low
      step(1,1,1,1,1,0,0,0, "R6 primary commit");
      step(1,1,1,1,1,1,0,0, "R6 primary in line");
      // R7 partner
      step(1,1,1,1,0,0,1,0, "R7 partner follows sync");
      step(1,1,1,1,0,1,0,0, "R7 partner ignores local de");
      step(1,1,1,1,0,1,1,0, "R7 partner sync high");
      // R4 partner link down
      step(1,1,0,1,0,0,1,0, "R4 partner link down");
      // R9 inversion in pair
      step(1,1,1,1,1,0,0,1, "R9 inversion in pair");
      step(1,1,1,0,1,0,0,1, "R9 inversion single ok");
      step(1,1,1,0,1,0,0,0, "R9 cleared");
      // R3 driver off; coincides with a commit
      step(1,0,1,1,1,0,0,0, "R3 driver off with commit");
      step(1,0,1,0,1,0,0,0, "R3 driver off single");
      // R4 primary link down
      step(1,1,0,1,1,0,0,0, "R4 primary link down");
      // R2 chip off
      step(0,1,1,0,1,0,0,0, "R2 chip off");
      step(0,0,0,1,0,1,1,1, "R2 chip off all low");
      step(1,1,1,0,1,0,0,0, "R2 recovered");
      // R10 varied stimulus, latency of one edge everywhere
      lfsr = 8'hA5;
      for (int i = 0; i < 60; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         step(lfsr[0] | lfsr[7], lfsr[1] | lfsr[6], lfsr[2] | lfsr[5], lfsr[3],
              lfsr[4], lfsr[5], lfsr[6], lfsr[7] & lfsr[0], "R10 mixed pattern");
      end
      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule